// File: doc/BRIEF.md
# Wakeup Pin Event Detector

The block watches a small set of external wakeup pins and records, per pin, that a wakeup condition was seen. Each pin has an enable bit and a polarity bit. A pin whose polarity selects the high level reacts to a low-to-high change. A pin whose polarity selects the low level reacts to a high-to-low change. Turning a pin on while its input already sits at the active level also counts as an event. Each event sets a sticky flag. Flags stay set until software clears them through a write-only clear register. The OR of all flags drives a single wakeup request line toward the power controller.

Pin inputs pass through a synchroniser inside the block, so they may be asynchronous. Software reaches the block through a simple word-wide register port with three addresses:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | enables, polarities and pad-pull fields |
| 1 | write-only | flag clear; always reads as 0 |
| 2 | read-only | flags |

The pad-pull fields are decoded into per-pin pull-up and pull-down outputs. These only configure the pads; the detector does not use them.

Top module: `wkup_pin_ctrl`

## Requirements
- R1: After reset the configuration word (address 0) reads 0, the flag word (address 2) reads 0, `wake_req_o` is 0 and no pull output is active.
- R2: With polarity 0, a pin that is enabled and changes from 0 to 1 sets its flag. The flag becomes visible at address 2, bit i, on the third rising clock edge after the pin changes, and not before.
- R3: With polarity 1, an enabled pin that changes from 1 to 0 sets its flag. A pin that is enabled while already high, with polarity 1, sets no flag.
- R4: A pin whose enable bit is 0 never sets its flag, however its input toggles.
- R5: Writing an enable bit from 0 to 1 while that pin already sits at its active level sets the flag on the clock edge that follows the write. This applies whether or not an edge occurs.
- R6: A flag stays set after its pin returns to the inactive level.
- R7: Writing address 1 clears flag i for each data bit i that is 1. Data bits that are 0 leave their flags unchanged.
- R8: Address 1 always reads as 0. Writes to address 2 change no flag.
- R9: When a new event and a clear of the same pin take effect on the same clock edge, the flag stays set.
- R10: `wake_req_o` is 1 exactly when at least one flag is set.
- R11: A pin's 2-bit pull field decodes as follows: 1 drives its `pull_up_o` bit, 2 drives its `pull_down_o` bit, and 0 or 3 drive neither.
- R12: The configuration word (address 0) holds the fields below. All other bits are ignored on write and read as 0.
  - Enable bits are at bits [3:0].
  - Polarity bits are at bits [7:4].
  - The pull field of pin i is at bits [9+2i:8+2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wkup_pin_i | input | 4 | Raw wakeup pin levels, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 config, 1 clear, 2 flags |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| wake_req_o | output | 1 | OR of all wakeup flags |
| pull_up_o | output | 4 | Per-pin pad pull-up configuration |
| pull_down_o | output | 4 | Per-pin pad pull-down configuration |

## Verification
Two functions can act on a flag in the same cycle: hardware setting it from a fresh pin edge, and software clearing it through address 1. The bench first sets a pin's flag and lets the pin fall back. It then raises the pin again and times a clear write of that bit so that the write lands on the very edge where the synchronised edge registers. The flag must still read 1 afterwards. A clear alone, on a quiet pin, must then bring it to 0.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    WK_ADDR_CFG  = 2'd0,
    WK_ADDR_CLR  = 2'd1,
    WK_ADDR_FLAG = 2'd2
  } wk_addr_e;

  typedef enum logic [1:0] {
    WK_PULL_NONE = 2'd0,
    WK_PULL_UP   = 2'd1,
    WK_PULL_DOWN = 2'd2,
    WK_PULL_RSVD = 2'd3
  } wk_pull_e;

  // returns {down, up}; reserved code acts as no pull
  function automatic logic [1:0] pull_decode(input logic [1:0] code);
    logic [1:0] res;
    res = 2'b00;
    if (code == WK_PULL_UP) res = 2'b01;
    else if (code == WK_PULL_DOWN) res = 2'b10;
    return res;
  endfunction
endpackage

// File: rtl/wkup_sync.sv
`timescale 1ns/1ps
module wkup_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_ff
      logic [STAGES-1:0][WIDTH-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pipe_q <= '0;
        end else begin
          pipe_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wkup_regs.sv
`timescale 1ns/1ps
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [1:0]          addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [NUM_PINS-1:0] flags_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_down_o,
  output logic [NUM_PINS-1:0] clr_o
);
  localparam int unsigned POL_LSB  = NUM_PINS;
  localparam int unsigned PULL_LSB = 2 * NUM_PINS;
  localparam int unsigned CFG_W    = 4 * NUM_PINS;

  wk_addr_e addr;
  assign addr = wk_addr_e'(addr_i);

  logic [NUM_PINS-1:0]      en_q, pol_q;
  logic [2*NUM_PINS-1:0]    pull_q;
  logic                     cfg_we;

  assign cfg_we = wr_i && (addr == WK_ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      pull_q <= '0;
    end else if (cfg_we) begin
      en_q   <= wdata_i[NUM_PINS-1:0];
      pol_q  <= wdata_i[POL_LSB +: NUM_PINS];
      pull_q <= wdata_i[PULL_LSB +: 2*NUM_PINS];
    end
  end

  assign clr_o = (wr_i && addr == WK_ADDR_CLR) ? wdata_i[NUM_PINS-1:0] : '0;
  assign en_o  = en_q;
  assign pol_o = pol_q;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pull
      logic [1:0] dec;
      assign dec            = pull_decode(pull_q[2*i +: 2]);
      assign pull_up_o[i]   = dec[0];
      assign pull_down_o[i] = dec[1];
    end
    if (CFG_W < REG_W) begin : g_unused
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[REG_W-1:CFG_W];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr)
      WK_ADDR_CFG: rdata_o[CFG_W-1:0] = {pull_q, pol_q, en_q};
      WK_ADDR_FLAG: rdata_o[NUM_PINS-1:0] = flags_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wkup_detect.sv
`timescale 1ns/1ps
module wkup_detect #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] pol_i,
  output logic [NUM_PINS-1:0] evt_o
);
  logic [NUM_PINS-1:0] lvl_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      en_q  <= '0;
    end else begin
      lvl_q <= lvl_i;
      en_q  <= en_i;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic act_now, act_prev;
      // previous sample judged against current polarity: polarity change alone is no event
      assign act_now  = lvl_i[i] ^ pol_i[i];
      assign act_prev = lvl_q[i] ^ pol_i[i];
      assign evt_o[i] = en_i[i] & act_now & (~act_prev | ~en_q[i]);
    end
  endgenerate
endmodule

// File: rtl/wkup_flags.sv
`timescale 1ns/1ps
module wkup_flags #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic                req_o
);
  logic [NUM_PINS-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | evt_i;
  end

  assign flag_o = flag_q;
  assign req_o  = |flag_q;
endmodule

// File: rtl/wkup_pin_ctrl.sv
`timescale 1ns/1ps
module wkup_pin_ctrl
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] wkup_pin_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                wake_req_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_down_o
);
  logic [NUM_PINS-1:0] pin_s, cfg_en, cfg_pol, clr_vec, evt_vec, flag_q;

  wkup_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(wkup_pin_i), .q_o(pin_s)
  );

  wkup_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flags_i(flag_q), .rdata_o(reg_rdata_o),
    .en_o(cfg_en), .pol_o(cfg_pol),
    .pull_up_o(pull_up_o), .pull_down_o(pull_down_o),
    .clr_o(clr_vec)
  );

  wkup_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i, .rst_ni, .lvl_i(pin_s), .en_i(cfg_en), .pol_i(cfg_pol), .evt_o(evt_vec)
  );

  wkup_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk_i, .rst_ni, .evt_i(evt_vec), .clr_i(clr_vec), .flag_o(flag_q), .req_o(wake_req_o)
  );
endmodule

// File: rtl/wkup_pin_ctrl_chk.sv
`timescale 1ns/1ps
module wkup_pin_ctrl_chk
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          reg_addr_i,
  input logic [REG_W-1:0]    reg_rdata_o,
  input logic                wake_req_o,
  input logic [NUM_PINS-1:0] pull_up_o,
  input logic [NUM_PINS-1:0] pull_down_o,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] evt_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] cfg_en
);
  a_r4_disabled_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & ~$past(flag_q) & ~$past(cfg_en)) == '0);

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~flag_q & $past(flag_q) & ~$past(clr_vec)) == '0);

  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec != '0) |=> ((flag_q & $past(clr_vec) & ~$past(evt_vec)) == '0));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vec != '0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));

  a_r8_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == WK_ADDR_CLR) |-> (reg_rdata_o == '0));

  a_r10_req_matches_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == WK_ADDR_FLAG) |-> (wake_req_o == (reg_rdata_o[NUM_PINS-1:0] != '0)));

  a_r11_pull_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_down_o) == '0);
endmodule

bind wkup_pin_ctrl wkup_pin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .wake_req_o(wake_req_o), .pull_up_o(pull_up_o), .pull_down_o(pull_down_o),
  .flag_q(flag_q), .evt_vec(evt_vec), .clr_vec(clr_vec), .cfg_en(cfg_en)
);

// File: tb/tb_wkup_pin_ctrl.sv
`timescale 1ns/1ps
module tb_wkup_pin_ctrl;
  localparam int N = 4;
  localparam int K_RDATA = 0, K_WAKE = 1, K_PU = 2, K_PD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake;
  logic [N-1:0] pu, pd;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t sb_q[$];
  event mon_go, mon_done;

  always #2.5 clk = ~clk;

  wkup_pin_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wkup_pin_i(pin), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_req_o(wake),
    .pull_up_o(pu), .pull_down_o(pd)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(mon_go);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] obs;
        it = sb_q.pop_front();
        case (it.kind)
          K_RDATA: obs = rdata;
          K_WAKE:  obs = {31'b0, wake};
          K_PU:    obs = {{(32-N){1'b0}}, pu};
          default: obs = {{(32-N){1'b0}}, pd};
        endcase
        n_tests++;
        if (obs !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual 0x%08h expected 0x%08h", it.req, it.kind, obs, it.exp);
        end
      end
      ->mon_done;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic expect_val(input int kind, input logic [1:0] a, input logic [31:0] e, input string req);
    item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.req = req;
    sb_q.push_back(it);
    #0;
    ->mon_go;
    @(mon_done);
  endtask

  task automatic expect_flags(input logic [N-1:0] f, input string req);
    expect_val(K_RDATA, 2'd2, {{(32-N){1'b0}}, f}, req);
  endtask

  initial begin
    #500_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    expect_val(K_RDATA, 2'd0, 32'h0, "R1 config");
    expect_flags('0, "R1 flags");
    expect_val(K_WAKE, 2'd0, 32'h0, "R1 wake");
    expect_val(K_PU, 2'd0, 32'h0, "R1 pull_up");
    expect_val(K_PD, 2'd0, 32'h0, "R1 pull_down");

    // R12 layout, R11 pull decode: pin0=1 up, pin1=2 down, pin2=3 none, pin3=0 none
    reg_write(2'd0, 32'hFFFF_3900);
    expect_val(K_RDATA, 2'd0, 32'h0000_3900, "R12 readback");
    expect_val(K_PU, 2'd0, 32'h1, "R11 pull_up");
    expect_val(K_PD, 2'd0, 32'h2, "R11 pull_down");

    // R2 rising edge on pin0, polarity 0
    reg_write(2'd0, 32'h0000_0001);
    pin[0] = 1'b1;
    tick(2);
    expect_flags('0, "R2 not before third edge");
    tick(1);
    expect_flags(4'b0001, "R2 flag on third edge");
    expect_val(K_WAKE, 2'd0, 32'h1, "R10 wake set");

    // R6 sticky
    pin[0] = 1'b0;
    tick(5);
    expect_flags(4'b0001, "R6 sticky");

    // R7 clear
    reg_write(2'd1, 32'h0000_0002);
    expect_flags(4'b0001, "R7 zero bits keep flag");
    reg_write(2'd1, 32'h0000_0001);
    expect_flags('0, "R7 clear bit");
    expect_val(K_WAKE, 2'd0, 32'h0, "R10 wake cleared");

    // R8 clear reads 0, flag word read-only
    expect_val(K_RDATA, 2'd1, 32'h0, "R8 clear reads zero");
    reg_write(2'd2, 32'h0000_000F);
    expect_flags('0, "R8 flag write ignored");

    // R3 falling edge on pin1 with polarity 1; enabling while high gives nothing
    pin[1] = 1'b1;
    tick(4);
    reg_write(2'd0, 32'h0000_0022);
    tick(3);
    expect_flags('0, "R3 enable while inactive");
    pin[1] = 1'b0;
    tick(2);
    expect_flags('0, "R3 not before third edge");
    tick(1);
    expect_flags(4'b0010, "R3 falling edge");
    reg_write(2'd1, 32'hF);

    // R4 disabled pin2 toggles
    pin[2] = 1'b1; tick(3);
    pin[2] = 1'b0; tick(3);
    pin[2] = 1'b1; tick(4);
    expect_flags('0, "R4 disabled pin");

    // R5 enable pin2 while already high
    reg_write(2'd0, 32'h0000_0026);
    expect_flags('0, "R5 not yet");
    tick(1);
    expect_flags(4'b0100, "R5 enable at active level");
    reg_write(2'd1, 32'hF);
    expect_flags('0, "R7 clear all");

    // R9 event and clear on the same edge
    pin[2] = 1'b0; tick(4);
    pin[2] = 1'b1; tick(4);
    expect_flags(4'b0100, "R9 preset flag");
    pin[2] = 1'b0; tick(4);
    pin[2] = 1'b1;
    tick(2);
    reg_write(2'd1, 32'h0000_0004);
    expect_flags(4'b0100, "R9 event wins over clear");
    reg_write(2'd1, 32'h0000_0004);
    expect_flags('0, "R9 later clear");

    // R10 multiple flags
    pin[1] = 1'b1; tick(4);
    pin[1] = 1'b0; pin[2] = 1'b0; tick(4);
    pin[2] = 1'b1; tick(4);
    expect_flags(4'b0110, "R10 two flags");
    reg_write(2'd1, 32'h0000_0002);
    expect_val(K_WAKE, 2'd0, 32'h1, "R10 one flag left");
    reg_write(2'd1, 32'h0000_0004);
    expect_val(K_WAKE, 2'd0, 32'h0, "R10 none left");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule